// File: doc/BRIEF.md
# Word and Doubleword Rotate Unit

This unit performs rotate-right operations for a 64-bit integer datapath. It receives an instruction word together with two 64-bit operands: the value to rotate (taken from the rt register) and, for the variable forms, the rotate amount (taken from the rs register). It produces the 64-bit value destined for the register named in the instruction's destination field.

Five rotate forms are recognised. The rotate forms reuse the function codes of the logical right shifts. A field that is zero for those shifts holds the value 1 in a rotate: the rs field for the immediate forms, the sa field for the variable forms. Word forms rotate the low 32 bits and sign-extend the result. Doubleword forms rotate all 64 bits.

Other encodings are flagged. An encoding that carries a shift function code but lacks the marker raises a not-mine flag, so another unit can handle it. Every remaining encoding raises an illegal flag. All outputs are registered and appear one cycle after a valid input.

Top module: `rotate_unit`

## Requirements
- R1: Opcode (bits 31:26) 000000, rs field (bits 25:21) 00001 and function (bits 5:0) 000010 rotate rtVal[31:0] right by the sa field (bits 10:6). The 32-bit result is sign-extended from bit 31 to 64 bits.
- R2: Opcode 000000, function 000110 and sa field 00001 rotate rtVal[31:0] right by rsVal[4:0], sign-extended. Bits 63:5 of rsVal have no effect.
- R3: Opcode 000000, rs field 00001 and function 111010 rotate all 64 bits of rtVal right by the sa field.
- R4: Opcode 000000, rs field 00001 and function 111110 rotate all 64 bits of rtVal right by sa plus 32.
- R5: Opcode 000000, function 010110 and sa field 00001 rotate all 64 bits of rtVal right by rsVal[5:0]. Bits 63:6 of rsVal have no effect.
- R6: A rotate amount of zero returns rtVal unchanged for the doubleword forms. For the word forms it returns rtVal[31:0] sign-extended.
- R7: An encoding with opcode 000000 and one of the five function codes whose marker field is not 00001 sets notMine with result 0. It leaves illegal clear.
- R8: Any other encoding sets illegal with result 0. This covers a nonzero opcode or any other function code. notMine stays clear.
- R9: outValid is high exactly one cycle after inValid. result, destReg (instruction bits 15:11) and the flags update only on a valid input. notMine and illegal are high only together with outValid.
- R10: After reset, outValid, result, destReg, notMine and illegal are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Instruction and operands are valid |
| instr | input | 32 | Instruction word |
| rtVal | input | 64 | Value operand |
| rsVal | input | 64 | Variable amount operand |
| outValid | output | 1 | Registered result is valid |
| result | output | 64 | Destination value |
| destReg | output | 5 | Destination register index |
| notMine | output | 1 | Shift encoding without rotate marker |
| illegal | output | 1 | Unrecognised encoding |

## Verification
The assertions check four properties on every cycle:
- the one-cycle valid latency;
- that notMine and illegal are never both set;
- that a flagged result is zero;
- that a zero-amount doubleword rotate passes the value through.

Only the bench's scenarios can show that each rotation amount is correct, including the amount masking and the plus-32 offset. The same holds for the sign extension of word results, and for the split between not-mine and illegal encodings. The bench compares every output against a bit-by-bit behavioural model on each clock.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int DATA_W = 64;
  localparam int WORD_W = 32;
  localparam int AMT_W  = $clog2(DATA_W);

  localparam logic [5:0] FN_WROT_IMM = 6'b000010;
  localparam logic [5:0] FN_WROT_VAR = 6'b000110;
  localparam logic [5:0] FN_DROT_IMM = 6'b111010;
  localparam logic [5:0] FN_DROT_P32 = 6'b111110;
  localparam logic [5:0] FN_DROT_VAR = 6'b010110;
  localparam logic [4:0] MARKER      = 5'b00001;

  typedef struct packed {
    logic             doRot;
    logic             wordMode;
    logic [AMT_W-1:0] amount;
    logic             notMine;
    logic             illegal;
  } rotCtl_t;
endpackage

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
(
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rsVal,
  output rotCtl_t           ctl
);
  logic [5:0] opField;
  logic [4:0] rsField;
  logic [4:0] saField;
  logic [5:0] fnField;

  assign opField = instr[31:26];
  assign rsField = instr[25:21];
  assign saField = instr[10:6];
  assign fnField = instr[5:0];

  always_comb begin
    ctl = '0;
    if (opField != 6'd0) begin
      ctl.illegal = 1'b1;
    end else begin
      unique case (fnField)
        FN_WROT_IMM: begin
          ctl.wordMode = 1'b1;
          ctl.amount   = {1'b0, saField};
          ctl.doRot    = (rsField == MARKER);
        end
        FN_WROT_VAR: begin
          ctl.wordMode = 1'b1;
          ctl.amount   = {1'b0, rsVal[4:0]};
          ctl.doRot    = (saField == MARKER);
        end
        FN_DROT_IMM: begin
          ctl.amount = {1'b0, saField};
          ctl.doRot  = (rsField == MARKER);
        end
        FN_DROT_P32: begin
          ctl.amount = {1'b1, saField};
          ctl.doRot  = (rsField == MARKER);
        end
        FN_DROT_VAR: begin
          ctl.amount = rsVal[AMT_W-1:0];
          ctl.doRot  = (saField == MARKER);
        end
        default: ctl.illegal = 1'b1;
      endcase
      ctl.notMine = !ctl.illegal && !ctl.doRot;
    end
  end
endmodule

// File: rtl/rot_barrel.sv
module rot_barrel #(
  parameter int W = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]  value,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  rotated
);
  logic [2*W-1:0] doubled;
  assign doubled = {value, value} >> amt;
  assign rotated = doubled[W-1:0];
endmodule

// File: rtl/rot_datapath.sv
module rot_datapath
  import rot_pkg::*;
(
  input  rotCtl_t           ctl,
  input  logic [DATA_W-1:0] rtVal,
  output logic [DATA_W-1:0] rotOut
);
  localparam int WAW = $clog2(WORD_W);

  logic [WORD_W-1:0] wordRot;
  logic [DATA_W-1:0] dwordRot;

  rot_barrel #(.W(WORD_W)) uWord (
    .value(rtVal[WORD_W-1:0]), .amt(ctl.amount[WAW-1:0]), .rotated(wordRot));
  rot_barrel #(.W(DATA_W)) uDword (
    .value(rtVal), .amt(ctl.amount), .rotated(dwordRot));

  always_comb begin
    if (!ctl.doRot)        rotOut = '0;
    else if (ctl.wordMode) rotOut = {{(DATA_W-WORD_W){wordRot[WORD_W-1]}}, wordRot};
    else                   rotOut = dwordRot;
  end

  always_comb begin
    if (ctl.doRot && !ctl.wordMode && ctl.amount == '0)
      assert_zero_amount_R6: assert (rotOut == rtVal);
  end
endmodule

// File: rtl/rotate_unit.sv
module rotate_unit
  import rot_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] instr,
  input  logic [63:0] rtVal,
  input  logic [63:0] rsVal,
  output logic        outValid,
  output logic [63:0] result,
  output logic [4:0]  destReg,
  output logic        notMine,
  output logic        illegal
);
  rotCtl_t           ctl;
  logic [DATA_W-1:0] rotOut;

  rot_decode   uDec (.instr(instr), .rsVal(rsVal), .ctl(ctl));
  rot_datapath uDp  (.ctl(ctl), .rtVal(rtVal), .rotOut(rotOut));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      destReg  <= '0;
      notMine  <= 1'b0;
      illegal  <= 1'b0;
    end else begin
      outValid <= inValid;
      notMine  <= inValid && ctl.notMine;
      illegal  <= inValid && ctl.illegal;
      if (inValid) begin
        result  <= rotOut;
        destReg <= instr[15:11];
      end
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({notMine, illegal}));
  assert_flag_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (notMine || illegal) |-> (result == 64'd0));
endmodule

// File: tb/rotate_unit_test.sv
module rotate_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] rtVal = '0;
  logic [63:0] rsVal = '0;
  logic        outValid;
  logic [63:0] result;
  logic [4:0]  destReg;
  logic        notMine;
  logic        illegal;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic        eValid = 0;
  logic [63:0] eResult = 0;
  logic [4:0]  eDest = 0;
  logic        eNot = 0;
  logic        eIll = 0;

  always #10 clk = ~clk;

  rotate_unit uut (.clk(clk), .rstN(rstN), .inValid(inValid), .instr(instr),
    .rtVal(rtVal), .rsVal(rsVal), .outValid(outValid), .result(result),
    .destReg(destReg), .notMine(notMine), .illegal(illegal));

  function automatic logic [31:0] enc(int op, int rs, int rt, int rd, int sa, int fn);
    enc = {op[5:0], rs[4:0], rt[4:0], rd[4:0], sa[4:0], fn[5:0]};
  endfunction

  function automatic logic [63:0] rotr(logic [63:0] x, int amt, int w);
    logic [63:0] r = '0;
    for (int i = 0; i < w; i++) r[i] = x[(i + amt) % w];
    if (w == 32) for (int i = 32; i < 64; i++) r[i] = r[31];
    return r;
  endfunction

  // Behavioural reference: updates expected registers for one clock.
  task automatic model(logic v, logic [31:0] ins, logic [63:0] rt, logic [63:0] rs);
    int op = ins[31:26], rsf = ins[25:21], sa = ins[10:6], fn = ins[5:0];
    logic [63:0] res = 0;
    logic nm = 0, il = 0;
    if (!rstN) begin
      eValid = 0; eResult = 0; eDest = 0; eNot = 0; eIll = 0; return;
    end
    eValid = v;
    if (op != 0) il = 1;
    else if (fn == 2)  begin if (rsf == 1) res = rotr(rt, sa, 32); else nm = 1; end
    else if (fn == 6)  begin if (sa == 1) res = rotr(rt, int'(rs[4:0]), 32); else nm = 1; end
    else if (fn == 58) begin if (rsf == 1) res = rotr(rt, sa, 64); else nm = 1; end
    else if (fn == 62) begin if (rsf == 1) res = rotr(rt, sa + 32, 64); else nm = 1; end
    else if (fn == 22) begin if (sa == 1) res = rotr(rt, int'(rs[5:0]), 64); else nm = 1; end
    else il = 1;
    eNot = v && nm;
    eIll = v && il;
    if (v) begin eResult = res; eDest = ins[15:11]; end
  endtask

  task automatic compare(string req);
    checks++;
    if (outValid !== eValid || result !== eResult || destReg !== eDest ||
        notMine !== eNot || illegal !== eIll) begin
      errors++;
      $display("FAIL %s: got v=%0b res=%h rd=%0d nm=%0b il=%0b exp v=%0b res=%h rd=%0d nm=%0b il=%0b",
        req, outValid, result, destReg, notMine, illegal,
        eValid, eResult, eDest, eNot, eIll);
    end
  endtask

  task automatic step(string req, logic v, logic [31:0] ins, logic [63:0] rt, logic [63:0] rs);
    inValid = v; instr = ins; rtVal = rt; rsVal = rs;
    @(posedge clk);
    model(v, ins, rt, rs);
    @(negedge clk);
    compare(req);
  endtask

  localparam logic [63:0] PAT = 64'h8123_4567_89AB_CDEF;

  initial begin
    @(negedge clk);
    step("R10", 0, 0, 0, 0);
    step("R10", 1, enc(0, 1, 2, 3, 4, 2), PAT, 0);
    rstN = 1;
    step("R10", 0, 0, 0, 0);
    step("R1", 1, enc(0, 1, 2, 7, 4, 2), PAT, 0);
    step("R1", 1, enc(0, 1, 2, 8, 31, 2), 64'h0000_0000_0000_0001, 0);
    step("R1", 1, enc(0, 1, 2, 9, 1, 2), 64'hFFFF_FFFF_0000_0001, 0);
    step("R2", 1, enc(0, 5, 2, 10, 1, 6), PAT, 64'hFFFF_FFFF_FFFF_FFE8);
    step("R2", 1, enc(0, 5, 2, 11, 1, 6), PAT, 64'h0000_0000_0000_0033);
    step("R3", 1, enc(0, 1, 2, 12, 8, 58), PAT, 0);
    step("R3", 1, enc(0, 1, 2, 13, 31, 58), PAT, 0);
    step("R4", 1, enc(0, 1, 2, 14, 0, 62), PAT, 0);
    step("R4", 1, enc(0, 1, 2, 15, 31, 62), PAT, 0);
    step("R5", 1, enc(0, 3, 2, 16, 1, 22), PAT, 64'hABCD_0000_0000_007F);
    step("R5", 1, enc(0, 3, 2, 17, 1, 22), PAT, 64'd40);
    step("R6", 1, enc(0, 1, 2, 18, 0, 58), PAT, 0);
    step("R6", 1, enc(0, 1, 2, 19, 0, 2), PAT, 0);
    step("R6", 1, enc(0, 3, 2, 20, 1, 6), 64'h0000_0000_7000_0001, 64'h20);
    step("R7", 1, enc(0, 0, 2, 21, 4, 2), PAT, 0);
    step("R7", 1, enc(0, 4, 2, 22, 0, 6), PAT, 5);
    step("R7", 1, enc(0, 2, 2, 23, 3, 62), PAT, 0);
    step("R8", 1, enc(8, 1, 2, 24, 4, 2), PAT, 0);
    step("R8", 1, enc(0, 1, 2, 25, 1, 3), PAT, 0);
    step("R9", 0, enc(0, 1, 2, 26, 4, 58), 64'h1234, 0);
    step("R9", 0, enc(8, 1, 2, 27, 4, 2), 64'h1234, 0);
    step("R9", 1, enc(0, 1, 2, 28, 16, 58), PAT, 0);
    step("R9", 0, 0, 0, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule